// File: doc/BRIEF.md
# Four-Leg Space-Vector Duty and Tick Calculator

This block sits between a tetrahedron selector and a PWM sequencer in a four-leg, two-level inverter controller. Each sample it takes a 6-bit region code, the normalized phase-to-neutral reference (three signed fixed-point components), and the switching period as a tick count. For the three active vectors it produces dwell times, and for the zero vector it produces the remaining time. All four are integer ticks.

The region code is a set of six pairwise comparison bits over the four values {0, va, vb, vc}. Together these bits fix the order of the four values. Each active duty is the gap between two neighbours in that order. This works because the inverse of the vector matrix holds only 0 and ±1, so every duty is a sum or difference of at most two components. No divider and no matrix is needed. The three duties are then scaled by the period, and the zero-vector count takes whatever is left.

The interface is a one-cycle input strobe and a one-cycle output strobe. A result appears two cycles after its input.

Top module: `svm4_duty_ticks`

## Requirements
- R1: While reset is asserted, and until the first result, `out_valid` is 0 and all four tick outputs are 0.
- R2: Each cycle with `in_valid` high produces exactly one cycle with `out_valid` high, two clock edges later. `out_valid` is never high otherwise, and strobes on consecutive cycles give results on consecutive cycles.
- R3: The region code holds six comparison bits, each 1 when the difference is >= 0:
  - bit0: va >= 0
  - bit1: vb >= 0
  - bit2: vc >= 0
  - bit3: va >= vb
  - bit4: vb >= vc
  - bit5: va >= vc

  The code equals the region pointer minus one.
- R4: Order {0, va, vb, vc} by the code bits, with the winner of each bit placed higher, so ties follow the bits. Call the result s3 >= s2 >= s1 >= s0. The duties are then d1 = s3 - s2, d2 = s2 - s1 and d3 = s1 - s0.
- R5: Each active tick count is floor(d × period / 2^FRAC), where the reference components are signed with FRAC fractional bits (FRAC = 14, so 1.0 = 16384).
- R6: A duty that comes out negative, because the reference disagrees slightly with the code, is taken as 0.
- R7: A duty above 1.0 is taken as 1.0. If the three active counts sum to more than the period, the zero-vector count is 0.
- R8: Otherwise the zero-vector count is the period minus the three active counts, so the four counts sum exactly to the period.
- R9: The tick outputs hold the last result on every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| region_code | input | 6 | Pairwise comparison bits (region pointer minus one) |
| ref_a | input | 16 | Phase a reference, signed, 14 fractional bits |
| ref_b | input | 16 | Phase b reference, signed, 14 fractional bits |
| ref_c | input | 16 | Phase c reference, signed, 14 fractional bits |
| period | input | 16 | Switching period in ticks |
| out_valid | output | 1 | Result strobe |
| ticks_zero | output | 16 | Zero-vector dwell in ticks |
| ticks_1 | output | 16 | First active vector dwell in ticks |
| ticks_2 | output | 16 | Second active vector dwell in ticks |
| ticks_3 | output | 16 | Third active vector dwell in ticks |

## Verification
The checker watches several properties on every cycle:
- the two-cycle strobe latency in both directions;
- that the outputs hold between results;
- that no active count exceeds the period of its own sample;
- that the four counts sum to the period, or else that the zero count saturates.

The following can only be shown by the bench's directed and pseudo-random scenarios, which compare each result against a model built from the requirements:
- the duty values themselves, chosen from the code ordering;
- tie handling;
- the clamping of a slightly negative duty;
- the floor rounding of each count.

// File: rtl/svm4_duty_ticks.sv
module svm4_duty_ticks #(
  parameter int FRAC = 14,
  parameter int PW   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [5:0]             region_code,
  input  logic signed [FRAC+1:0] ref_a,
  input  logic signed [FRAC+1:0] ref_b,
  input  logic signed [FRAC+1:0] ref_c,
  input  logic [PW-1:0]          period,
  output logic                   out_valid,
  output logic [PW-1:0]          ticks_zero,
  output logic [PW-1:0]          ticks_1,
  output logic [PW-1:0]          ticks_2,
  output logic [PW-1:0]          ticks_3
);
  localparam int W  = FRAC + 2;
  localparam int DW = FRAC + 1;
  localparam logic signed [W:0] ONE_S = (W+1)'(1 << FRAC);

  logic [1:0] rk_a, rk_b, rk_c;
  assign rk_a = 2'(region_code[0]) + 2'(region_code[3]) + 2'(region_code[5]);
  assign rk_b = 2'(region_code[1]) + 2'(!region_code[3]) + 2'(region_code[4]);
  assign rk_c = 2'(region_code[2]) + 2'(!region_code[4]) + 2'(!region_code[5]);

  logic signed [W-1:0] ord [4];
  always_comb begin
    for (int r = 0; r < 4; r++) begin
      ord[r] = ((rk_a == 2'(r)) ? ref_a : '0)
             | ((rk_b == 2'(r)) ? ref_b : '0)
             | ((rk_c == 2'(r)) ? ref_c : '0);
    end
  end

  function automatic logic [DW-1:0] clamp_duty(input logic signed [W:0] x);
    if (x < 0)          return '0;
    else if (x > ONE_S) return ONE_S[DW-1:0];
    else                return x[DW-1:0];
  endfunction

  logic signed [W:0] gap [3];
  assign gap[0] = {ord[3][W-1], ord[3]} - {ord[2][W-1], ord[2]};
  assign gap[1] = {ord[2][W-1], ord[2]} - {ord[1][W-1], ord[1]};
  assign gap[2] = {ord[1][W-1], ord[1]} - {ord[0][W-1], ord[0]};

  logic          v1;
  logic [DW-1:0] duty_q [3];
  logic [PW-1:0] per_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      per_q <= '0;
      for (int i = 0; i < 3; i++) duty_q[i] <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        per_q <= period;
        for (int i = 0; i < 3; i++) duty_q[i] <= clamp_duty(gap[i]);
      end
    end
  end

  logic [PW-1:0] act [3];
  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_scale
      logic [DW+PW-1:0] prod;
      assign prod   = (DW+PW)'(duty_q[g]) * (DW+PW)'(per_q);
      assign act[g] = prod[FRAC+PW-1:FRAC];
    end
  endgenerate

  logic [PW+1:0] act_sum;
  logic [PW-1:0] rest;
  assign act_sum = (PW+2)'(act[0]) + (PW+2)'(act[1]) + (PW+2)'(act[2]);
  assign rest    = (act_sum > (PW+2)'(per_q)) ? '0 : per_q - act_sum[PW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      ticks_zero <= '0;
      ticks_1    <= '0;
      ticks_2    <= '0;
      ticks_3    <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        ticks_zero <= rest;
        ticks_1    <= act[0];
        ticks_2    <= act[1];
        ticks_3    <= act[2];
      end
    end
  end
endmodule

// File: rtl/svm4_duty_ticks_chk.sv
module svm4_duty_ticks_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [PW-1:0] period,
  input logic          out_valid,
  input logic [PW-1:0] ticks_zero,
  input logic [PW-1:0] ticks_1,
  input logic [PW-1:0] ticks_2,
  input logic [PW-1:0] ticks_3
);
  logic [PW+1:0] act_sum;
  assign act_sum = (PW+2)'(ticks_1) + (PW+2)'(ticks_2) + (PW+2)'(ticks_3);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable({ticks_zero, ticks_1, ticks_2, ticks_3}));

  p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ticks_1 <= $past(period, 2)) && (ticks_2 <= $past(period, 2))
                  && (ticks_3 <= $past(period, 2)));

  p_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && act_sum <= (PW+2)'($past(period, 2)))
      |-> act_sum + (PW+2)'(ticks_zero) == (PW+2)'($past(period, 2)));

  p_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && act_sum > (PW+2)'($past(period, 2))) |-> ticks_zero == '0);
endmodule

bind svm4_duty_ticks svm4_duty_ticks_chk #(.PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .period(period),
  .out_valid(out_valid), .ticks_zero(ticks_zero), .ticks_1(ticks_1),
  .ticks_2(ticks_2), .ticks_3(ticks_3)
);

// File: tb/svm4_duty_ticks_tb_top.sv
module svm4_duty_ticks_tb_top;
  localparam int FRAC = 14;
  localparam int ONE  = 1 << FRAC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [5:0] region_code = '0;
  logic signed [15:0] ref_a = '0, ref_b = '0, ref_c = '0;
  logic [15:0] period = '0;
  logic out_valid;
  logic [15:0] ticks_zero, ticks_1, ticks_2, ticks_3;

  always #5 clk = ~clk;

  svm4_duty_ticks #(.FRAC(FRAC), .PW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .region_code(region_code),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .period(period),
    .out_valid(out_valid), .ticks_zero(ticks_zero), .ticks_1(ticks_1),
    .ticks_2(ticks_2), .ticks_3(ticks_3)
  );

  typedef struct {
    int t0; int t1; int t2; int t3; int cyc; string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lfsr = 32'h1234_5678;
  logic [15:0] last_t0 = 0, last_t1 = 0, last_t2 = 0, last_t3 = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int code_of(int a, int b, int c);
    int k = 0;
    if (a >= 0) k |= 1;
    if (b >= 0) k |= 2;
    if (c >= 0) k |= 4;
    if (a >= b) k |= 8;
    if (b >= c) k |= 16;
    if (a >= c) k |= 32;
    return k;
  endfunction

  function automatic int clampd(int x);
    if (x < 0) return 0;
    if (x > ONE) return ONE;
    return x;
  endfunction

  // Expected counts from R3..R8
  function automatic exp_t model(int code, int a, int b, int c, int per, string tag);
    exp_t e;
    int s [4];
    int ra, rb, rc, rz;
    int d1, d2, d3, sum;
    ra = ((code >> 0) & 1) + ((code >> 3) & 1) + ((code >> 5) & 1);
    rb = ((code >> 1) & 1) + (1 - ((code >> 3) & 1)) + ((code >> 4) & 1);
    rc = ((code >> 2) & 1) + (1 - ((code >> 4) & 1)) + (1 - ((code >> 5) & 1));
    rz = 3 - ((code >> 0) & 1) - ((code >> 1) & 1) - ((code >> 2) & 1);
    s[ra] = a; s[rb] = b; s[rc] = c; s[rz] = 0;
    d1 = clampd(s[3] - s[2]);
    d2 = clampd(s[2] - s[1]);
    d3 = clampd(s[1] - s[0]);
    e.t1 = int'((longint'(d1) * per) >>> FRAC);
    e.t2 = int'((longint'(d2) * per) >>> FRAC);
    e.t3 = int'((longint'(d3) * per) >>> FRAC);
    sum = e.t1 + e.t2 + e.t3;
    e.t0 = (sum > per) ? 0 : per - sum;
    e.cyc = 0;
    e.tag = tag;
    return e;
  endfunction

  task automatic send(int code, int a, int b, int c, int per, string tag);
    exp_t e;
    @(negedge clk);
    region_code = 6'(code);
    ref_a = 16'(a); ref_b = 16'(b); ref_c = 16'(c);
    period = 16'(per);
    in_valid = 1'b1;
    e = model(code, a, b, c, per, tag);
    e.cyc = cyc + 2;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          errors++; checks++;
          $display("FAIL R2: out_valid with no pending input, actual=1 expected=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          checks++;
          if (cyc != e.cyc) begin
            errors++;
            $display("FAIL R2: result cycle actual=%0d expected=%0d", cyc, e.cyc);
          end
          checks++;
          if (ticks_zero != 16'(e.t0) || ticks_1 != 16'(e.t1) ||
              ticks_2 != 16'(e.t2) || ticks_3 != 16'(e.t3)) begin
            errors++;
            $display("FAIL %s: ticks actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                     e.tag, ticks_zero, ticks_1, ticks_2, ticks_3, e.t0, e.t1, e.t2, e.t3);
          end
        end
      end else begin
        checks++;
        if (ticks_zero != last_t0 || ticks_1 != last_t1 ||
            ticks_2 != last_t2 || ticks_3 != last_t3) begin
          errors++;
          $display("FAIL R9: outputs moved without out_valid actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                   ticks_zero, ticks_1, ticks_2, ticks_3, last_t0, last_t1, last_t2, last_t3);
        end
      end
      last_t0 = ticks_zero; last_t1 = ticks_1; last_t2 = ticks_2; last_t3 = ticks_3;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || ticks_zero !== 0 || ticks_1 !== 0 || ticks_2 !== 0 || ticks_3 !== 0) begin
      errors++;
      $display("FAIL R1: reset outputs actual=%0b/%0d/%0d/%0d/%0d expected=0/0/0/0/0",
               out_valid, ticks_zero, ticks_1, ticks_2, ticks_3);
    end
    rst_n = 1'b1;
    idle(2);

    send(0, -8192, -4096, -2048, 1000, "R4 region 1");
    idle(3);
    send(12, -2000, -5000, 3000, 4000, "R4 region 13");
    idle(3);
    send(63, 8000, 4000, 1000, 20000, "R5 region 64");
    idle(3);
    send(code_of(3000, 3000, -1000), 3000, 3000, -1000, 12345, "R3 tie a=b");
    idle(3);
    send(63, 8000, 4000, -100, 5000, "R6 negative duty");
    idle(3);
    send(code_of(24576, 1000, -4096), 24576, 1000, -4096, 3000, "R7 duty above one");
    idle(3);
    send(code_of(12000, -12000, 0), 12000, -12000, 0, 1000, "R7 zero saturates");
    idle(3);
    send(code_of(5000, -3000, 1500), 5000, -3000, 1500, 0, "R5 zero period");
    idle(3);
    send(code_of(5000, -3000, 1500), 5000, -3000, 1500, 65535, "R8 full period");
    idle(3);
    send(code_of(-7000, 2000, 6000), -7000, 2000, 6000, 777, "R2 burst");
    send(code_of(1, -1, 0), 1, -1, 0, 777, "R2 burst");
    send(code_of(9000, 9000, 9000), 9000, 9000, 9000, 777, "R2 burst");
    send(code_of(-9000, 0, 9000), -9000, 0, 9000, 777, "R2 burst");
    idle(5);

    for (int n = 0; n < 300; n++) begin
      int a, b, c, p;
      lfsr = lfsr * 1103515245 + 12345; a = ((lfsr >>> 8) & 32767) - 16384;
      lfsr = lfsr * 1103515245 + 12345; b = ((lfsr >>> 8) & 32767) - 16384;
      lfsr = lfsr * 1103515245 + 12345; c = ((lfsr >>> 8) & 32767) - 16384;
      lfsr = lfsr * 1103515245 + 12345; p = (lfsr >>> 8) & 65535;
      send(code_of(a, b, c), a, b, c, p, "R8 sweep");
      if ((n % 3) == 0) idle(2);
    end
    idle(6);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2: pending results actual=%0d expected=0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule